// File: doc/BRIEF.md
# Partitioned Packed Integer Adder

This block is a packed integer adder with a registered output. Two wide operand vectors enter with an element-size code and an add/subtract select. One adder datapath is split at run time into independent lanes. Each lane adds or subtracts its own slice of the operands, and every lane uses the same operation in the same cycle. The carry chain is cut at each lane boundary, so a lane wraps modulo two to the power of its width and never disturbs its neighbour.

The datapath is built from 8-bit slices. At each slice boundary the incoming carry comes from one of two sources. If the boundary is a lane edge for the selected element size, the carry is the operation's carry seed: 0 for add, 1 for subtract. Otherwise it is the carry out of the slice below. Subtraction inverts the second operand and injects a carry of 1 at every lane's lowest bit.

The result and a valid flag are registered. They appear one clock after an accepted input. The result stays unchanged until the next accepted input. The default width is 64 bits, and a 128-bit build doubles the number of lanes in every mode.

Top module: `simd_lane_adder`

## Requirements
- R1: With element-size code 00, a 64-bit build forms 8 lanes of 8 bits, and each lane result is the lane sum modulo 256.
- R2: With element-size code 01, a 64-bit build forms 4 lanes of 16 bits, and each lane result is the lane sum modulo 2^16.
- R3: With element-size code 10, a 64-bit build forms 2 lanes of 32 bits, and each lane result is the lane sum modulo 2^32.
- R4: With element-size code 11, the operands are added as whole 64-bit elements modulo 2^64.
- R5: A carry out of the top bit of any lane is discarded and never changes the next lane up.
- R6: With op_sub = 1 (0 selects add), each lane result is opnd_a minus opnd_b modulo 2^lane width, and a borrow never crosses a lane boundary.
- R7: Lane 0 occupies bits [w-1:0] of each vector, and lane k occupies bits [(k+1)w-1:kw], where w is the lane width.
- R8: out_valid is high in exactly the cycle after each cycle in which in_valid is high, and low otherwise.
- R9: While in_valid is low, result keeps its last value whatever the operand, size and op inputs do.
- R10: During reset, out_valid and result are 0.
- R11: With DATA_W = 128, codes 00, 01, 10 and 11 give 16, 8, 4 and 2 independent lanes of 8, 16, 32 and 64 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| in_valid | input | 1 | Operands and controls are accepted this cycle |
| esz | input | 2 | Element size: 00 = 8, 01 = 16, 10 = 32, 11 = 64 bits |
| op_sub | input | 1 | 0 = add, 1 = subtract (a - b) |
| opnd_a | input | DATA_W | First operand vector |
| opnd_b | input | DATA_W | Second operand vector |
| out_valid | output | 1 | Result register holds a new result |
| result | output | DATA_W | Packed lane results |

## Verification
Suppose a lane-edge cut is decoded wrongly for one element size. The first operation in that size whose low lane carries out would show a changed low bit in the lane above it, one clock after the input. A wrong carry seed corrupts every lane's lowest bit in the same cycle, and it can also add a spurious +1 to a sum. A stray load enable on the result register shows up as a result change while in_valid is low. A broken valid pipeline shows up as a missing or extra out_valid pulse. Operands chosen as all-ones plus one in every lane, and zero minus one in every lane, make each of these faults visible on the first operation.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;

  localparam int SLICE_W = 8;

  typedef enum logic [1:0] {
    ESZ_8  = 2'b00,
    ESZ_16 = 2'b01,
    ESZ_32 = 2'b10,
    ESZ_64 = 2'b11
  } esz_t;

endpackage

// File: rtl/simd_reset_sync.sv
module simd_reset_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q    <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      stage_q    <= 1'b1;
      rst_sync_n <= stage_q;
    end
  end

endmodule

// File: rtl/simd_lane_cut.sv
module simd_lane_cut
  import simd_add_pkg::*;
#(
  parameter int NSLICE = 8
) (
  input  esz_t              esz,
  output logic [NSLICE-1:0] cut
);

  // A slice starts a lane when its index is a multiple of the lane size in slices.
  logic [31:0] idx_mask;

  always_comb begin
    idx_mask = (32'd1 << esz) - 32'd1;
    for (int s = 0; s < NSLICE; s++) begin
      cut[s] = ((32'(s) & idx_mask) == 32'd0);
    end
  end

endmodule

// File: rtl/simd_slice_chain.sv
module simd_slice_chain
  import simd_add_pkg::*;
#(
  parameter int NSLICE = 8,
  localparam int W     = NSLICE * SLICE_W
) (
  input  logic [W-1:0]      a,
  input  logic [W-1:0]      b,
  input  logic [NSLICE-1:0] cut,
  input  logic              sub,
  output logic [W-1:0]      sum
);

  logic [W-1:0]      b_eff;
  logic [NSLICE-1:0] cin;
  logic [NSLICE-1:0] cout;

  assign b_eff = sub ? ~b : b;

  genvar s;
  generate
    for (s = 0; s < NSLICE; s++) begin : g_slice
      localparam int LO = s * SLICE_W;

      if (s == 0) begin : g_first
        assign cin[s] = sub;
      end else begin : g_next
        // Lane edge: seed carry; inside a lane: ripple from the slice below.
        assign cin[s] = cut[s] ? sub : cout[s-1];
      end

      if (s == NSLICE - 1) begin : g_top
        assign sum[LO +: SLICE_W] = a[LO +: SLICE_W] + b_eff[LO +: SLICE_W]
                                  + {{(SLICE_W-1){1'b0}}, cin[s]};
        assign cout[s] = 1'b0;
      end else begin : g_mid
        logic [SLICE_W:0] wide;
        assign wide = {1'b0, a[LO +: SLICE_W]} + {1'b0, b_eff[LO +: SLICE_W]}
                    + {{SLICE_W{1'b0}}, cin[s]};
        assign sum[LO +: SLICE_W] = wide[SLICE_W-1:0];
        assign cout[s]            = wide[SLICE_W];
      end
    end
  endgenerate

endmodule

// File: rtl/simd_result_reg.sv
module simd_result_reg #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] d,
  output logic         vld,
  output logic [W-1:0] q
);

  logic [W-1:0] q_nxt;
  logic         vld_nxt;

  always_comb begin
    q_nxt   = q;
    vld_nxt = load;
    if (load) begin
      q_nxt = d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q   <= '0;
      vld <= 1'b0;
    end else begin
      q   <= q_nxt;
      vld <= vld_nxt;
    end
  end

endmodule

// File: rtl/simd_lane_adder.sv
module simd_lane_adder
  import simd_add_pkg::*;
#(
  parameter int DATA_W  = 64,
  localparam int NSLICE = DATA_W / SLICE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [1:0]        esz,
  input  logic              op_sub,
  input  logic [DATA_W-1:0] opnd_a,
  input  logic [DATA_W-1:0] opnd_b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);

  logic              rst_sync_n;
  logic [NSLICE-1:0] cut;
  logic [DATA_W-1:0] sum;
  esz_t              esz_e;

  assign esz_e = esz_t'(esz);

  simd_reset_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  simd_lane_cut #(.NSLICE(NSLICE)) u_cut (
    .esz (esz_e),
    .cut (cut)
  );

  simd_slice_chain #(.NSLICE(NSLICE)) u_chain (
    .a   (opnd_a),
    .b   (opnd_b),
    .cut (cut),
    .sub (op_sub),
    .sum (sum)
  );

  simd_result_reg #(.W(DATA_W)) u_out (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .load  (in_valid),
    .d     (sum),
    .vld   (out_valid),
    .q     (result)
  );

endmodule

// File: rtl/simd_lane_adder_chk.sv
module simd_lane_adder_chk #(
  parameter int DATA_W = 64
) (
  input logic              clk,
  input logic              rst_sync_n,
  input logic              in_valid,
  input logic [1:0]        esz,
  input logic              op_sub,
  input logic [DATA_W-1:0] opnd_a,
  input logic [DATA_W-1:0] opnd_b,
  input logic              out_valid,
  input logic [DATA_W-1:0] result
);

  // Set one clock after reset release so that $past never reaches into reset.
  logic armed;
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) armed <= 1'b0;
    else             armed <= 1'b1;
  end

  p_reset_clear_r10: assert property (@(posedge clk)
    !rst_sync_n |-> (!out_valid && result == '0));

  p_valid_latency_r8: assert property (@(posedge clk) disable iff (!rst_sync_n || !armed)
    out_valid == $past(in_valid));

  p_hold_idle_r9: assert property (@(posedge clk) disable iff (!rst_sync_n || !armed)
    !$past(in_valid) |-> $stable(result));

  p_byte_lane0_r1: assert property (@(posedge clk) disable iff (!rst_sync_n || !armed)
    $past(in_valid && esz == 2'b00 && !op_sub) |->
      result[7:0] == 8'($past(opnd_a[7:0]) + $past(opnd_b[7:0])));

  p_half_sub_lane0_r6: assert property (@(posedge clk) disable iff (!rst_sync_n || !armed)
    $past(in_valid && esz == 2'b01 && op_sub) |->
      result[15:0] == 16'($past(opnd_a[15:0]) - $past(opnd_b[15:0])));

  p_whole_add_r4: assert property (@(posedge clk) disable iff (!rst_sync_n || !armed)
    $past(in_valid && esz == 2'b11 && !op_sub) |->
      result[63:0] == 64'($past(opnd_a[63:0]) + $past(opnd_b[63:0])));

endmodule

bind simd_lane_adder simd_lane_adder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .in_valid   (in_valid),
  .esz        (esz),
  .op_sub     (op_sub),
  .opnd_a     (opnd_a),
  .opnd_b     (opnd_b),
  .out_valid  (out_valid),
  .result     (result)
);

// File: tb/simd_lane_adder_tb.sv
module simd_lane_adder_tb;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         in_valid;
  logic [1:0]   esz;
  logic         op_sub;
  logic [127:0] wa, wb;
  logic         ov_n, ov_w;
  logic [63:0]  res_n;
  logic [127:0] res_w;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  simd_lane_adder #(.DATA_W(64)) u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .esz(esz), .op_sub(op_sub),
    .opnd_a(wa[63:0]), .opnd_b(wb[63:0]), .out_valid(ov_n), .result(res_n)
  );

  simd_lane_adder #(.DATA_W(128)) u_dut_wide (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .esz(esz), .op_sub(op_sub),
    .opnd_a(wa), .opnd_b(wb), .out_valid(ov_w), .result(res_w)
  );

  function automatic logic [127:0] model(input logic [127:0] a, input logic [127:0] b,
                                         input logic [1:0] e, input logic s, input int w);
    int lw;
    logic [127:0] r;
    lw = 8 << e;
    r  = '0;
    for (int base = 0; base < w; base += lw) begin
      logic [63:0] m, x, y, z;
      m = (lw == 64) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'd1 << lw) - 64'd1);
      x = 64'(a >> base) & m;
      y = 64'(b >> base) & m;
      z = (s ? (x - y) : (x + y)) & m;
      r = r | (128'(z) << base);
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one operation, then sample one cycle later away from the edge.
  task automatic run_op(input logic [127:0] a, input logic [127:0] b,
                        input logic [1:0] e, input logic s, input string tag);
    @(negedge clk);
    in_valid = 1'b1; wa = a; wb = b; esz = e; op_sub = s;
    @(negedge clk);
    in_valid = 1'b0;
    check({tag, " valid"}, {127'd0, ov_n}, 128'd1);
    check({tag, " result"}, {64'd0, res_n}, model(a, b, e, s, 64));
  endtask

  task automatic t_reset;
    rst_n = 1'b0; in_valid = 1'b0; esz = 2'b00; op_sub = 1'b0; wa = '0; wb = '0;
    repeat (3) @(negedge clk);
    check("R10 out_valid in reset", {127'd0, ov_n}, 128'd0);
    check("R10 result in reset", {64'd0, res_n}, 128'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R10 out_valid after release", {127'd0, ov_n}, 128'd0);
  endtask

  task automatic t_byte;
    // R1 / R7: distinct lanes, lane 0 at LSBs
    run_op(128'h0807_0605_0403_0201, 128'h1010_1010_1010_1010, 2'b00, 1'b0, "R1 bytes");
    check("R7 lane0 at LSB", {120'd0, res_n[7:0]}, 128'h11);
    check("R7 lane7 at MSB", {120'd0, res_n[63:56]}, 128'h18);
    run_op(128'h7F80_FF01_C3A5_5A3C, 128'h0180_0101_3D5B_A6C4, 2'b00, 1'b0, "R1 bytes mix");
  endtask

  task automatic t_half;
    run_op(128'h1234_FFFF_8000_00FF, 128'h1111_0002_8000_0001, 2'b01, 1'b0, "R2 halves");
  endtask

  task automatic t_word;
    run_op(128'hFFFF_FFFF_7FFF_FFFF, 128'h0000_0002_0000_0001, 2'b10, 1'b0, "R3 words");
  endtask

  task automatic t_whole;
    run_op(128'h00FF_FFFF_FFFF_FFFF, 128'h0000_0000_0000_0001, 2'b11, 1'b0, "R4 whole");
    check("R4 full carry ripple", {64'd0, res_n}, 128'h0100_0000_0000_0000);
    run_op(128'hFFFF_FFFF_FFFF_FFFF, 128'h0000_0000_0000_0002, 2'b11, 1'b0, "R4 wrap");
  endtask

  task automatic t_carry_iso;
    for (int e = 0; e < 3; e++) begin
      run_op(128'hFFFF_FFFF_FFFF_FFFF, 128'h0101_0101_0101_0101 & model(128'd0, 128'd0, 2'(e), 1'b0, 64) |
             (e == 0 ? 128'h0101_0101_0101_0101 : e == 1 ? 128'h0001_0001_0001_0001 : 128'h0000_0001_0000_0001),
             2'(e), 1'b0, "R5 carry isolation");
      check("R5 all lanes zero", {64'd0, res_n}, 128'd0);
    end
  endtask

  task automatic t_sub;
    run_op(128'h0000_0000_0000_0000, 128'h0101_0101_0101_0101, 2'b00, 1'b1, "R6 byte borrow");
    check("R6 byte lanes all FF", {64'd0, res_n}, 128'hFFFF_FFFF_FFFF_FFFF);
    run_op(128'h0000_1234_0005_8000, 128'h0001_0234_0007_0001, 2'b01, 1'b1, "R6 half sub");
    run_op(128'h0000_0010_0000_0000, 128'h0000_0001_0000_0001, 2'b10, 1'b1, "R6 word borrow");
    run_op(128'h0000_0001_0000_0000, 128'h0000_0000_0000_0001, 2'b11, 1'b1, "R6 whole sub");
  endtask

  task automatic t_latency;
    @(negedge clk);
    check("R8 idle no valid", {127'd0, ov_n}, 128'd0);
    run_op(128'h5, 128'h6, 2'b00, 1'b0, "R8 pulse");
    @(negedge clk);
    check("R8 valid drops", {127'd0, ov_n}, 128'd0);
    // back-to-back
    @(negedge clk);
    in_valid = 1'b1; wa = 128'h10; wb = 128'h1; esz = 2'b00; op_sub = 1'b0;
    @(negedge clk);
    check("R8 first of pair", {64'd0, res_n}, 128'h11);
    wa = 128'h20; wb = 128'h2;
    @(negedge clk);
    in_valid = 1'b0;
    check("R8 second of pair valid", {127'd0, ov_n}, 128'd1);
    check("R8 second of pair", {64'd0, res_n}, 128'h22);
  endtask

  task automatic t_hold;
    logic [63:0] keep;
    run_op(128'hAAAA_5555_AAAA_5555, 128'h1111_1111_1111_1111, 2'b01, 1'b0, "R9 setup");
    keep = res_n;
    @(negedge clk);
    wa = '1; wb = '1; esz = 2'b11; op_sub = 1'b1;
    repeat (3) @(negedge clk);
    check("R9 held while idle", {64'd0, res_n}, {64'd0, keep});
    check("R9 no valid while idle", {127'd0, ov_n}, 128'd0);
  endtask

  task automatic t_wide;
    logic [127:0] a, b;
    a = 128'hFFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF_FFFF;
    b = 128'h0123_4567_89AB_CDEF_FEDC_BA98_7654_3211;
    for (int e = 0; e < 4; e++) begin
      for (int s = 0; s < 2; s++) begin
        @(negedge clk);
        in_valid = 1'b1; wa = a; wb = b; esz = 2'(e); op_sub = 1'(s);
        @(negedge clk);
        in_valid = 1'b0;
        check("R11 wide valid", {127'd0, ov_w}, 128'd1);
        check("R11 wide lanes", res_w, model(a, b, 2'(e), 1'(s), 128));
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    t_reset();
    t_byte();
    t_half();
    t_word();
    t_whole();
    t_carry_iso();
    t_sub();
    t_latency();
    t_hold();
    t_wide();
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

endmodule